// File: doc/BRIEF.md
# Two-Level Pixel Hit Arbiter with Gray Timestamp

This block reads hits out of a pixel matrix organised as rows of pixels. Inside each row a fixed-priority picker chooses one requesting pixel; a second fixed-priority picker then chooses among the rows that have a candidate. The chosen pixel receives an acknowledge through a four-phase request/acknowledge handshake. In the same clock edge, an event word for a downstream FIFO is written. The word carries a 13-bit Gray-coded timestamp, the flat pixel address and a bit that flags further pending hits.

Pixels hold their request level until they see their acknowledge, and then drop it. Configuration inputs enable individual columns and individual rows. A pixel takes part only when both its column and its row are enabled. While the downstream FIFO signals full, no new grant is issued.

Top module: `hit_readout`

## Requirements
- R1: While `rst_n` is low at a clock edge, all acknowledges, `evt_wr` and `evt_word` are zero after that edge.
- R2: Among enabled requests in the same row, the pixel with the lowest column index is served first.
- R3: Among rows holding an enabled request, the lowest row index is served first, before any pixel of a higher row.
- R4: A pixel whose column enable is 0 is never acknowledged and never reported, and it does not set the pending bit of another event.
- R5: A pixel whose row enable is 0 is never acknowledged and never reported, and it does not set the pending bit of another event.
- R6: At most one acknowledge is high at a time. It stays high and unchanged while the granted pixel keeps its request. It falls in the cycle after the request falls.
- R7: Each grant writes exactly one event. `evt_wr` is a single-cycle pulse that rises together with the acknowledge, and it never fires without a grant.
- R8: Event word layout: bit 23 is 1 when, at the grant edge, at least one enabled request other than the winner is pending. Bits 22:10 hold the timestamp. Bits 9:0 hold the address, with the row index in bits 9:5 and the column index in bits 4:0.
- R9: The timestamp is g = b ^ (b >> 1) of a 13-bit binary counter. The counter is 0 after reset, increments on every clock edge, and wraps at 8192. The value stored is the counter value held just before the grant edge.
- R10: While `fifo_full` is 1 at a clock edge, no grant is issued at that edge. Pending requests are served once it returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_req | input | ROWS*COLS | Level request per pixel, index row*COLS+col |
| pix_ack | output | ROWS*COLS | Acknowledge per pixel, same indexing |
| col_enable | input | COLS | 1 lets the column take part |
| row_enable | input | ROWS | 1 lets the row take part |
| fifo_full | input | 1 | Downstream full flag; blocks new grants |
| evt_wr | output | 1 | Write strobe, one cycle per granted hit |
| evt_word | output | 24 | Pending bit, Gray timestamp, row and column |

## Verification
The main function is driven with several patterns. A single lone pixel checks the word layout. Several pixels in one row separate column priority from arrival order. Pixels spread over several rows, with the lowest row index holding two hits, show that row order dominates column order. In every burst the pending bit must fall to 0 exactly on the last event. Masked columns and disabled rows are mixed with live requests, so the pending bit shows whether masked pixels leak into the flag; re-enabling them then shows they were only held back. Further patterns cover a pixel that keeps its request for several cycles, a burst held behind a full FIFO, the top-corner address, and a grant after the timestamp counter has wrapped.

// File: rtl/hit_readout_pkg.sv
// Shared constants and types for the pixel hit readout.
// Assumes a 24-bit event word: pending bit, 13-bit stamp, 5+5 address.
package hit_readout_pkg;
    localparam int TS_W        = 13;
    localparam int ADDR_W      = 10;
    localparam int COL_FIELD_W = 5;
    localparam int ROW_FIELD_W = ADDR_W - COL_FIELD_W;
    localparam int WORD_W      = 1 + TS_W + ADDR_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic                   more;
        logic [TS_W-1:0]        stamp;
        logic [ROW_FIELD_W-1:0] row;
        logic [COL_FIELD_W-1:0] col;
    } hit_word_t;
endpackage

// File: rtl/fixed_prio_pick.sv
// Fixed-priority picker: the lowest set index of req wins.
// Also reports whether any request besides the winner is set.
// Assumes N >= 2; purely combinational.
module fixed_prio_pick #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic             more
);
    // Scan from the top down so the lowest set bit is the last to assign.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Any request present, and more than one present (lowest bit cleared).
    always_comb begin
        any  = |req;
        more = |(req & (req - N'(1)));
    end
endmodule

// File: rtl/gray_stamp.sv
// Free-running binary counter with a Gray-coded view of its value.
// Assumes the counter wraps naturally at 2**W.
module gray_stamp #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] gray
);
    logic [W-1:0] bin_q;

    // Count every cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_q + W'(1);
    end

    // Gray view of the current count.
    always_comb gray = bin_q ^ (bin_q >> 1);
endmodule

// File: rtl/hit_readout.sv
// Two-level hit arbiter: per-row fixed-priority pickers feed a line
// picker. The winner is acknowledged with a four-phase handshake and
// one event word is written per grant. Assumes COLS <= 32, ROWS <= 32
// and that pixels hold their request until acknowledged.
module hit_readout
    import hit_readout_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROWS*COLS-1:0] pix_req,
    output logic [ROWS*COLS-1:0] pix_ack,
    input  logic [COLS-1:0]      col_enable,
    input  logic [ROWS-1:0]      row_enable,
    input  logic                 fifo_full,
    output logic                 evt_wr,
    output logic [WORD_W-1:0]    evt_word
);
    localparam int NPIX   = ROWS * COLS;
    localparam int ROW_IW = $clog2(ROWS);
    localparam int COL_IW = $clog2(COLS);
    localparam int PIX_IW = $clog2(NPIX);

    logic [COLS-1:0]   row_req [ROWS];
    logic [COL_IW-1:0] row_col [ROWS];
    logic [ROWS-1:0]   row_any;
    logic [ROWS-1:0]   row_more;

    // Row level: mask each row, then pick its lowest enabled column.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_req[r] = pix_req[r*COLS +: COLS] & col_enable
                          & {COLS{row_enable[r]}};
        fixed_prio_pick #(.N(COLS), .IDX_W(COL_IW)) u_pick (
            .req  (row_req[r]),
            .any  (row_any[r]),
            .idx  (row_col[r]),
            .more (row_more[r])
        );
    end

    logic              hit_any;
    logic              line_more;
    logic [ROW_IW-1:0] sel_row;
    logic [COL_IW-1:0] sel_col;
    logic              sel_more;

    // Line level: pick the lowest row that has a candidate.
    fixed_prio_pick #(.N(ROWS), .IDX_W(ROW_IW)) u_line (
        .req  (row_any),
        .any  (hit_any),
        .idx  (sel_row),
        .more (line_more)
    );

    // Winning column and the pending flag for the whole matrix.
    always_comb begin
        sel_col  = row_col[sel_row];
        sel_more = row_more[sel_row] | line_more;
    end

    logic [TS_W-1:0] stamp;

    gray_stamp #(.W(TS_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .gray  (stamp)
    );

    hit_word_t word_next;

    // Assemble the event word for the current candidate.
    always_comb begin
        word_next.more  = sel_more;
        word_next.stamp = stamp;
        word_next.row   = ROW_FIELD_W'(sel_row);
        word_next.col   = COL_FIELD_W'(sel_col);
    end

    hs_state_e         state;
    logic [ROW_IW-1:0] win_row;
    logic [COL_IW-1:0] win_col;
    logic [PIX_IW-1:0] win_flat;

    // Flat index of the held winner.
    always_comb win_flat = PIX_IW'(win_row) * PIX_IW'(COLS) + PIX_IW'(win_col);

    // Handshake sequencer: grant, write once, wait for request release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            win_row  <= '0;
            win_col  <= '0;
            evt_wr   <= 1'b0;
            evt_word <= '0;
        end else begin
            evt_wr <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (hit_any && !fifo_full) begin
                        state    <= ST_ACK;
                        win_row  <= sel_row;
                        win_col  <= sel_col;
                        evt_wr   <= 1'b1;
                        evt_word <= word_next;
                    end
                end
                ST_ACK: begin
                    if (!pix_req[win_flat]) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Acknowledge decode: only the held winner, only while granted.
    for (genvar i = 0; i < NPIX; i++) begin : g_ack
        assign pix_ack[i] = (state == ST_ACK) && (win_flat == PIX_IW'(i));
    end
endmodule

// File: rtl/hit_readout_chk.sv
// Protocol checker for hit_readout, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module hit_readout_chk #(
    parameter int ROWS = 16,
    parameter int COLS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ROWS*COLS-1:0] pix_req,
    input logic [ROWS*COLS-1:0] pix_ack,
    input logic                 fifo_full,
    input logic                 evt_wr
);
    // R6: never more than one pixel acknowledged.
    assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pix_ack));

    // R6: acknowledge held while the granted pixel still requests.
    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pix_ack & pix_req)) |=> $stable(pix_ack));

    // R7: the write strobe lasts one cycle.
    assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> !evt_wr);

    // R7: a new acknowledge comes with a write.
    assert_write_on_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|pix_ack) |-> evt_wr);

    // R7: no write without an acknowledge.
    assert_no_orphan_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |-> (|pix_ack));

    // R10: full at an edge blocks a write after it.
    assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> !evt_wr);
endmodule

bind hit_readout hit_readout_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_req   (pix_req),
    .pix_ack   (pix_ack),
    .fifo_full (fifo_full),
    .evt_wr    (evt_wr)
);

// File: tb/hit_readout_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected events, the monitor
// compares every write against the queue head.
module hit_readout_test;
    localparam int ROWS = 16;
    localparam int COLS = 32;
    localparam int NPIX = ROWS * COLS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPIX-1:0]   pix_req = '0;
    logic [NPIX-1:0]   pix_ack;
    logic [COLS-1:0]   col_en = '1;
    logic [ROWS-1:0]   row_en = '1;
    logic              fifo_full = 1'b0;
    logic              evt_wr;
    logic [23:0]       evt_word;

    hit_readout #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_req    (pix_req),
        .pix_ack    (pix_ack),
        .col_enable (col_en),
        .row_enable (row_en),
        .fifo_full  (fifo_full),
        .evt_wr     (evt_wr),
        .evt_word   (evt_word)
    );

    always #2 clk = ~clk;

    int drv_vec = 0, drv_fail = 0, mon_vec = 0, mon_fail = 0;
    int cyc = 0;
    bit done = 0;
    logic [10:0] exp_q [$];
    string       tag_q [$];

    // Reference cycle count since reset.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [12:0] gray13(input logic [12:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic int pix(input int r, input int c);
        return r * COLS + c;
    endfunction

    function automatic logic [NPIX-1:0] en_vec();
        logic [NPIX-1:0] v = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                v[pix(r, c)] = row_en[r] & col_en[c];
        return v;
    endfunction

    task automatic expect_hit(input int r, input int c, input bit more, input string tag);
        exp_q.push_back({more, 5'(r), 5'(c)});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare every write with the head of the queue.
    bit prev_wr = 0;
    always @(negedge clk) begin
        if (rst_n && evt_wr) begin
            mon_vec++;
            if (prev_wr) begin
                mon_fail++;
                $display("FAIL R7 back-to-back write act=%b exp=0", prev_wr);
            end
            if (exp_q.size() == 0) begin
                mon_fail++;
                $display("FAIL R7 unexpected write act=%h exp=none", evt_word);
            end else begin
                logic [10:0] e;
                string       t;
                logic [23:0] w;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                w = {e[10], gray13(13'(cyc - 1)), e[9:0]};
                if (evt_word !== w) begin
                    mon_fail++;
                    $display("FAIL %s R8 R9 word act=%h exp=%h", t, evt_word, w);
                end
            end
        end
        prev_wr <= rst_n && evt_wr;
    end

    // Pixel model plus driver: raise set, serve acks after hold cycles.
    task automatic run_burst(input logic [NPIX-1:0] set, input int hold);
        int age = 0;
        bit released = 0;
        logic [NPIX-1:0] last_ack = '0;
        @(negedge clk);
        pix_req = pix_req | set;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            drv_vec++;
            if ((pix_ack & ~en_vec()) != '0) begin
                drv_fail++;
                $display("FAIL R4 R5 masked ack act=%h exp=0", pix_ack & ~en_vec());
            end
            if (released) begin
                drv_vec++;
                if (|pix_ack) begin
                    drv_fail++;
                    $display("FAIL R6 ack not released act=%h exp=0", pix_ack);
                end
                released = 0;
                age = 0;
            end else if (|pix_ack) begin
                age++;
                if (age > 1 && pix_ack !== last_ack) begin
                    drv_fail++;
                    $display("FAIL R6 ack changed act=%h exp=%h", pix_ack, last_ack);
                end
                last_ack = pix_ack;
                if (age > hold) begin
                    pix_req = pix_req & ~pix_ack;
                    released = 1;
                end
            end
            if (!released && !(|pix_ack) && !(|(pix_req & en_vec()))) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_drained(input string tag);
        drv_vec++;
        if (exp_q.size() != 0) begin
            drv_fail++;
            $display("FAIL %s missing events act=%0d exp=0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        logic [NPIX-1:0] s;
        repeat (4) @(negedge clk);
        // R1: reset state
        drv_vec++;
        if (pix_ack !== '0 || evt_wr !== 1'b0 || evt_word !== '0) begin
            drv_fail++;
            $display("FAIL R1 reset act=%b/%h exp=0/0", evt_wr, evt_word);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: single pixel, layout
        expect_hit(0, 0, 0, "R8");
        s = '0; s[pix(0, 0)] = 1; run_burst(s, 0);
        check_drained("R8");

        // R2: same row, column order
        expect_hit(2, 3, 1, "R2"); expect_hit(2, 7, 1, "R2"); expect_hit(2, 30, 0, "R2");
        s = '0; s[pix(2, 7)] = 1; s[pix(2, 3)] = 1; s[pix(2, 30)] = 1;
        run_burst(s, 0);
        check_drained("R2");

        // R3: row order dominates column order
        expect_hit(1, 4, 1, "R3"); expect_hit(1, 20, 1, "R3");
        expect_hit(9, 4, 1, "R3"); expect_hit(15, 4, 0, "R3");
        s = '0; s[pix(9, 4)] = 1; s[pix(1, 4)] = 1; s[pix(15, 4)] = 1; s[pix(1, 20)] = 1;
        run_burst(s, 0);
        check_drained("R3");

        // R4: masked column held back, no pending-bit leak, then served
        col_en[5] = 1'b0;
        expect_hit(3, 6, 0, "R4");
        s = '0; s[pix(0, 5)] = 1; s[pix(3, 5)] = 1; s[pix(3, 6)] = 1;
        run_burst(s, 0);
        check_drained("R4");
        col_en[5] = 1'b1;
        expect_hit(0, 5, 1, "R4"); expect_hit(3, 5, 0, "R4");
        run_burst('0, 0);
        check_drained("R4");

        // R5: disabled row ignored, then withdrawn and re-enabled silently
        row_en[7] = 1'b0;
        expect_hit(8, 0, 0, "R5");
        s = '0; s[pix(7, 0)] = 1; s[pix(8, 0)] = 1;
        run_burst(s, 0);
        check_drained("R5");
        pix_req[pix(7, 0)] = 1'b0;
        row_en[7] = 1'b1;
        run_burst('0, 0);
        check_drained("R5");

        // R6: long request hold, top-corner address
        expect_hit(15, 31, 0, "R6");
        s = '0; s[pix(15, 31)] = 1; run_burst(s, 5);
        check_drained("R6");

        // R10: full blocks grants, then release
        fifo_full = 1'b1;
        @(negedge clk);
        pix_req[pix(4, 4)] = 1'b1; pix_req[pix(2, 9)] = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            drv_vec++;
            if (|pix_ack || evt_wr) begin
                drv_fail++;
                $display("FAIL R10 grant while full act=%b exp=0", evt_wr);
            end
        end
        expect_hit(2, 9, 1, "R10"); expect_hit(4, 4, 0, "R10");
        fifo_full = 1'b0;
        run_burst('0, 0);
        check_drained("R10");

        // R9: timestamp after counter wrap
        repeat (9000) @(negedge clk);
        expect_hit(6, 12, 0, "R9");
        s = '0; s[pix(6, 12)] = 1; run_burst(s, 1);
        check_drained("R9");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==",
                 drv_vec + mon_vec, drv_fail + mon_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==",
                     drv_vec + mon_vec, drv_fail + mon_fail + 1);
            $finish;
        end
    end
endmodule